// File: doc/BRIEF.md
# Mode-Multiplexed Programming Port

This block is the host-facing front end for the programming mode. An external programmer has a single byte-wide data path and a pair of select pins. Over successive phases it uses that path to supply a 14-bit flash address in two pieces, to supply a byte to write, and to read a byte back. The port assembles the address from the two address phases and holds it. A write-data phase hands a complete write cycle (address and data) to the downstream command decoder. In the read phase the port turns the shared path around and drives out the byte that storage returns for the held address.

Each valid transfer is marked by a strobe. The port does nothing until an upstream entry sequencer grants access. While access is not granted, the port ignores strobes, keeps the bus released and issues no write cycles. The split bus (`bus_i`, `bus_o`, `bus_oe`) is meant to be joined into one tri-state pad at the chip edge.

Top module: `hostprog_port`

## Requirements
- R1: After reset, `rd_addr` is 0, `wr_valid` is 0 and `bus_oe` is 0.
- R2: With `mode` = 2'b00, a strobe loads `bus_i[5:0]` into address bits 13..8. The new address appears on `rd_addr` after the next clock edge, and `bus_i[7:6]` have no effect.
- R3: With `mode` = 2'b01, a strobe loads `bus_i[7:0]` into address bits 7..0. The new address appears on `rd_addr` after the next clock edge.
- R4: With `mode` = 2'b10, a strobe causes `wr_valid` to be high for the cycle after the edge. In that cycle `wr_addr` equals the held 14-bit address and `wr_data` equals the `bus_i` value that was sampled.
- R5: With `mode` = 2'b11 and access granted, `bus_oe` is 1 and `bus_o` equals `rd_data`, the storage byte for `rd_addr`.
- R6: In modes 2'b00, 2'b01 and 2'b10, `bus_oe` is 0.
- R7: Without a strobe, the held address does not change and no write cycle is issued. A strobe in mode 2'b11 also leaves the address unchanged.
- R8: While `grant` is 0, `bus_oe` stays 0, `wr_valid` stays 0, and strobes in any mode leave the held address unchanged.
- R9: A high-address load leaves address bits 7..0 unchanged, and a low-address load leaves bits 13..8 unchanged.
- R10: Strobes in mode 2'b10 on consecutive cycles produce one write cycle each, back to back. Each carries its own data byte. `wr_valid` falls in the cycle after the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant | input | 1 | Access granted by the entry sequencer |
| mode | input | 2 | Phase select: 00 addr high, 01 addr low, 10 write data, 11 read |
| strobe | input | 1 | Marks a valid transfer this cycle |
| bus_i | input | 8 | Shared bus, inbound value |
| bus_o | output | 8 | Shared bus, outbound value |
| bus_oe | output | 1 | Drive enable for the shared bus |
| wr_valid | output | 1 | One-cycle write cycle to the command decoder |
| wr_addr | output | 14 | Address of the write cycle |
| wr_data | output | 8 | Data of the write cycle |
| rd_addr | output | 14 | Held address, presented to storage |
| rd_data | input | 8 | Storage byte for `rd_addr` |

## Verification
The bench sets bus bits 7..6 to ones during a high-address load. A port that latched the full byte would show a `rd_addr` with bits beyond 13 or a wrong high field. The bench also loads each address half separately and checks that the other half survives, since a port that cleared the whole register would lose it. Back-to-back write strobes check for a port that merges or drops pulses or reuses stale data. With the grant withheld, strobes are sent in every mode to catch a port that leaks address updates, write cycles or bus drive before access.

// File: rtl/hostprog_pkg.sv
package hostprog_pkg;
   typedef enum logic [1:0] {
      PH_ADDR_HI = 2'b00,
      PH_ADDR_LO = 2'b01,
      PH_WDATA   = 2'b10,
      PH_RDATA   = 2'b11
   } phase_e;
endpackage

// File: rtl/hostprog_addr_latch.sv
module hostprog_addr_latch #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi,
   input  logic              ld_lo,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] addr
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic [HI_W-1:0]   hi_q;
   logic [DATA_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (ld_hi) hi_q <= din[HI_W-1:0];
         if (ld_lo) lo_q <= din;
      end
   end

   assign addr = {hi_q, lo_q};
endmodule

// File: rtl/hostprog_wr_issue.sv
module hostprog_wr_issue #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= fire;
         if (fire) begin
            wr_addr <= addr;
            wr_data <= din;
         end
      end
   end
endmodule

// File: rtl/hostprog_rd_drive.sv
module hostprog_rd_drive #(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_phase,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] bus_o,
   output logic              bus_oe
);
   assign bus_oe = rd_phase;

   generate
      if (READ_REG) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= rd_data;
         end
         assign bus_o = q;
      end else begin : g_comb
         assign bus_o = rd_data;
      end
   endgenerate
endmodule

// File: rtl/hostprog_port.sv
module hostprog_port
   import hostprog_pkg::*;
#(
   parameter int ADDR_W   = 14,
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant,
   input  logic [1:0]        mode,
   input  logic              strobe,
   input  logic [DATA_W-1:0] bus_i,
   output logic [DATA_W-1:0] bus_o,
   output logic              bus_oe,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data
);
   generate
      if (ADDR_W <= DATA_W || ADDR_W > 2 * DATA_W) begin : g_bad_width
         $error("hostprog_port: ADDR_W must lie in (DATA_W, 2*DATA_W]");
      end
   endgenerate

   phase_e phase;
   logic   xfer;
   logic   ld_hi, ld_lo, fire_wr, rd_phase;

   assign phase    = phase_e'(mode);
   assign xfer     = grant & strobe;
   assign ld_hi    = xfer && (phase == PH_ADDR_HI);
   assign ld_lo    = xfer && (phase == PH_ADDR_LO);
   assign fire_wr  = xfer && (phase == PH_WDATA);
   assign rd_phase = grant && (phase == PH_RDATA);

   hostprog_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_hi (ld_hi),
      .ld_lo (ld_lo),
      .din   (bus_i),
      .addr  (rd_addr)
   );

   hostprog_wr_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire_wr),
      .addr     (rd_addr),
      .din      (bus_i),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   hostprog_rd_drive #(.DATA_W(DATA_W), .READ_REG(READ_REG)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_phase (rd_phase),
      .rd_data  (rd_data),
      .bus_o    (bus_o),
      .bus_oe   (bus_oe)
   );
endmodule

// File: rtl/hostprog_port_chk.sv
module hostprog_port_chk #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              grant,
   input logic [1:0]        mode,
   input logic              strobe,
   input logic [DATA_W-1:0] bus_i,
   input logic              bus_oe,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] rd_addr
);
   localparam int HI_W = ADDR_W - DATA_W;

   // R4
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && strobe && mode == 2'b10) |=> wr_valid);

   // R4
   wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && strobe && mode == 2'b10) |=> (wr_addr == $past(rd_addr)));

   // R2
   hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && strobe && mode == 2'b00) |=>
         (rd_addr[ADDR_W-1:DATA_W] == $past(bus_i[HI_W-1:0])));

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && strobe) |=> $stable(rd_addr));

   // R8
   no_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |-> !bus_oe);

   // R8
   no_write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |=> !wr_valid);
endmodule

bind hostprog_port hostprog_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .grant    (grant),
   .mode     (mode),
   .strobe   (strobe),
   .bus_i    (bus_i),
   .bus_oe   (bus_oe),
   .wr_valid (wr_valid),
   .wr_addr  (wr_addr),
   .rd_addr  (rd_addr)
);

// File: tb/hostprog_port_tb_top.sv
module hostprog_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        grant = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        strobe = 1'b0;
   logic [7:0]  bus_i = 8'h00;
   logic [7:0]  bus_o;
   logic        bus_oe;
   logic        wr_valid;
   logic [13:0] wr_addr;
   logic [7:0]  wr_data;
   logic [13:0] rd_addr;
   logic [7:0]  rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   // storage model seen through the read port
   function automatic logic [7:0] mem_f(input logic [13:0] a);
      return a[7:0] ^ {a[13:8], 2'b01};
   endfunction
   assign rd_data = mem_f(rd_addr);

   hostprog_port dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (grant),
      .mode     (mode),
      .strobe   (strobe),
      .bus_i    (bus_i),
      .bus_o    (bus_o),
      .bus_oe   (bus_oe),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic step(input logic [1:0] m, input logic s, input logic [7:0] d);
      @(negedge clk);
      mode = m; strobe = s; bus_i = d;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      check("R1", "rd_addr", 32'(rd_addr), 32'h0);
      check("R1", "wr_valid", 32'(wr_valid), 32'h0);
      check("R1", "bus_oe", 32'(bus_oe), 32'h0);
   endtask

   task automatic t_disabled();
      grant = 1'b0;
      step(2'b00, 1'b1, 8'h3F);
      check("R8", "addr hi ignored", 32'(rd_addr), 32'h0);
      step(2'b01, 1'b1, 8'h77);
      check("R8", "addr lo ignored", 32'(rd_addr), 32'h0);
      step(2'b10, 1'b1, 8'h99);
      step(2'b11, 1'b1, 8'h00);
      check("R8", "no write", 32'(wr_valid), 32'h0);
      check("R8", "no drive", 32'(bus_oe), 32'h0);
      step(2'b11, 1'b0, 8'h00);
   endtask

   task automatic t_addr();
      @(negedge clk) grant = 1'b1;
      step(2'b00, 1'b1, 8'hFF);
      check("R2", "hi load, bits 7:6 dropped", 32'(rd_addr), 32'h3F00);
      step(2'b01, 1'b1, 8'h5A);
      check("R3", "lo load", 32'(rd_addr), 32'h3F5A);
      step(2'b00, 1'b1, 8'h12);
      check("R9", "hi load keeps lo", 32'(rd_addr), 32'h125A);
      step(2'b01, 1'b1, 8'hC3);
      check("R9", "lo load keeps hi", 32'(rd_addr), 32'h12C3);
      step(2'b01, 1'b0, 8'h00);
   endtask

   task automatic t_write();
      step(2'b10, 1'b1, 8'hA5);
      check("R4", "wr_valid", 32'(wr_valid), 32'h1);
      check("R4", "wr_addr", 32'(wr_addr), 32'h12C3);
      check("R4", "wr_data", 32'(wr_data), 32'hA5);
      step(2'b10, 1'b0, 8'h00);
      check("R10", "pulse ends", 32'(wr_valid), 32'h0);
      step(2'b10, 1'b1, 8'h11);
      check("R10", "b2b first valid", 32'(wr_valid), 32'h1);
      check("R10", "b2b first data", 32'(wr_data), 32'h11);
      step(2'b10, 1'b1, 8'h22);
      check("R10", "b2b second valid", 32'(wr_valid), 32'h1);
      check("R10", "b2b second data", 32'(wr_data), 32'h22);
      step(2'b10, 1'b0, 8'h00);
      check("R10", "b2b end", 32'(wr_valid), 32'h0);
   endtask

   task automatic t_nostrobe();
      step(2'b00, 1'b0, 8'h01);
      check("R7", "no strobe hi", 32'(rd_addr), 32'h12C3);
      step(2'b01, 1'b0, 8'h02);
      check("R7", "no strobe lo", 32'(rd_addr), 32'h12C3);
      step(2'b10, 1'b0, 8'h03);
      check("R7", "no strobe write", 32'(wr_valid), 32'h0);
   endtask

   task automatic t_read();
      step(2'b00, 1'b0, 8'h00);
      check("R6", "oe mode 00", 32'(bus_oe), 32'h0);
      step(2'b01, 1'b0, 8'h00);
      check("R6", "oe mode 01", 32'(bus_oe), 32'h0);
      step(2'b10, 1'b0, 8'h00);
      check("R6", "oe mode 10", 32'(bus_oe), 32'h0);
      step(2'b11, 1'b1, 8'hEE);
      check("R5", "oe mode 11", 32'(bus_oe), 32'h1);
      check("R5", "read data", 32'(bus_o), 32'(mem_f(14'h12C3)));
      check("R7", "read strobe keeps addr", 32'(rd_addr), 32'h12C3);
      step(2'b00, 1'b1, 8'h2B);
      step(2'b01, 1'b1, 8'h0F);
      step(2'b11, 1'b0, 8'h00);
      check("R5", "read new addr", 32'(bus_o), 32'(mem_f(14'h2B0F)));
      @(negedge clk) grant = 1'b0;
      #1;
      check("R8", "grant drop releases bus", 32'(bus_oe), 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_disabled();
      t_addr();
      t_write();
      t_nostrobe();
      t_read();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule